// File: doc/BRIEF.md
# Transmit Maintenance Alarm Controller

This block decides which maintenance alarms a framer's transmitter should send toward the far end. It watches the receive-side defect indications (loss of signal, loss of frame alignment, loss of multiframe alignment), a loss-of-transmit-clock flag and a per-CRC-error strobe. From these it produces transmit requests for AIS, yellow (remote alarm), multiframe yellow and far-end block error (FEBE). Each automatic response has its own enable. A manual request line for each alarm forces that alarm on, whatever the enables are.

Two responses need state of their own. The first is a reframe-timeout timer. It counts millisecond ticks while frame alignment stays lost, and once a programmable number of ticks has passed it raises yellow, even when the direct frame-loss response is disabled. The second is a FEBE pulse queue. It turns every accepted CRC error strobe into exactly one FEBE pulse, and it holds strobes that arrive faster than pulses can be sent. Inserting the alarm bits into the frame is left to a downstream formatter.

Top module: `txalarm_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after reset, all five outputs are low.
- R2: When `en_ais_los` and `rx_los` are both high, `tx_ais` is high on the next cycle. When `en_ais_los` is low, `rx_los` has no effect on `tx_ais`.
- R3: When `en_ais_tloc` and `tx_clk_lost` are both high, both `tx_ais` and `ais_clk_alt` are high on the next cycle. `ais_clk_alt` is never high without `tx_ais`, and it stays low when AIS comes only from loss of signal or from the manual request.
- R4: When `en_yel_frm` and `rx_frame_lost` are both high, `tx_yel` is high on the next cycle.
- R5: With `en_yel_tmo` high, the timer counts the `ms_tick` pulses seen from the cycle after `rx_frame_lost` rises. After TMO_MS of these ticks (default 100), `tx_yel` goes high two cycles after the last counted tick. It stays high while `rx_frame_lost` stays high. After TMO_MS-1 ticks, `tx_yel` is still low.
- R6: When `rx_frame_lost` falls, the timer clears. Yellow that comes only from the timer drops two cycles later. The next loss of alignment counts from zero again.
- R7: When `en_myel` and `rx_mf_lost` are both high, `tx_myel` is high on the next cycle.
- R8: With `en_febe` high, every cycle in which `crc_err` is high produces exactly one FEBE pulse on `tx_febe`. Each pulse is one cycle wide, and consecutive pulses are separated by at least two low cycles. Up to FEBE_QMAX outstanding strobes are held without loss. With `en_febe` low, `crc_err` produces no pulse.
- R9: Each manual request (`man_ais`, `man_yel`, `man_myel`, `man_febe`) forces its output high on the next cycle, whatever the enables and defects are.
- R10: An automatic AIS, frame-loss yellow or multiframe yellow drops on the cycle after its cause or its enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_los | input | 1 | Receive loss of signal |
| tx_clk_lost | input | 1 | Loss of transmit clock |
| rx_frame_lost | input | 1 | Receive frame alignment lost |
| rx_mf_lost | input | 1 | Receive multiframe alignment lost |
| crc_err | input | 1 | One-cycle strobe per received CRC error |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| en_ais_los | input | 1 | Enable AIS on loss of signal |
| en_ais_tloc | input | 1 | Enable AIS on loss of transmit clock |
| en_yel_frm | input | 1 | Enable yellow on frame loss |
| en_yel_tmo | input | 1 | Enable yellow on reframe timeout |
| en_myel | input | 1 | Enable multiframe yellow on multiframe loss |
| en_febe | input | 1 | Enable FEBE on CRC error |
| man_ais | input | 1 | Manual AIS request |
| man_yel | input | 1 | Manual yellow request |
| man_myel | input | 1 | Manual multiframe yellow request |
| man_febe | input | 1 | Manual FEBE request (level) |
| tx_ais | output | 1 | Send AIS |
| ais_clk_alt | output | 1 | Switch the AIS clock to the alternate source |
| tx_yel | output | 1 | Send yellow alarm |
| tx_myel | output | 1 | Send multiframe yellow |
| tx_febe | output | 1 | FEBE request pulse |

## Verification
The assertions assume that every input changes only between clock edges and is held for at least one full cycle. They also assume that `crc_err` and `ms_tick` are single-cycle strobes. The FEBE spacing check further assumes that `man_febe` is low over the cycles it looks at. The stimulus drives every input one time unit after a rising edge and returns each strobe low after one cycle. It keeps `man_febe` low during the FEBE pulse-count phases and raises it only in the manual-request phase, after the queued pulses have drained.

The timer states are TM_IDLE (alignment present), TM_COUNT (loss seen, counting ticks) and TM_EXPIRED (timeout reached, held). The transitions are: TM_IDLE→TM_COUNT when the loss is seen; TM_COUNT→TM_EXPIRED on the last counted tick; TM_COUNT→TM_IDLE and TM_EXPIRED→TM_IDLE when alignment returns. The FEBE sequencer states are FB_IDLE, FB_PULSE and FB_GAP. The transitions are: FB_IDLE→FB_PULSE when a strobe is pending; FB_PULSE→FB_GAP always; FB_GAP→FB_IDLE always.

// File: rtl/txalarm_pkg.sv
package txalarm_pkg;

    typedef enum logic [1:0] {
        TM_IDLE    = 2'd0,
        TM_COUNT   = 2'd1,
        TM_EXPIRED = 2'd2
    } tmo_state_e;

    typedef enum logic [1:0] {
        FB_IDLE  = 2'd0,
        FB_PULSE = 2'd1,
        FB_GAP   = 2'd2
    } febe_state_e;

endpackage

// File: rtl/txalarm_reframe_timer.sv
module txalarm_reframe_timer
    import txalarm_pkg::*;
#(
    parameter int TMO_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_lost,
    input  logic ms_tick,
    output logic expired
);
    localparam int CW = (TMO_MS > 1) ? $clog2(TMO_MS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TMO_MS - 1);

    tmo_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TM_IDLE: begin
                cnt_d = '0;
                if (frame_lost) state_d = TM_COUNT;
            end
            TM_COUNT: begin
                if (!frame_lost) begin
                    state_d = TM_IDLE;
                    cnt_d   = '0;
                end else if (ms_tick) begin
                    if (cnt_q == LAST) state_d = TM_EXPIRED;
                    else               cnt_d   = cnt_q + 1'b1;
                end
            end
            TM_EXPIRED: begin
                if (!frame_lost) begin
                    state_d = TM_IDLE;
                    cnt_d   = '0;
                end
            end
            default: state_d = TM_IDLE;
        endcase
    end

    assign expired = (state_q == TM_EXPIRED);

endmodule

// File: rtl/txalarm_febe_queue.sv
module txalarm_febe_queue
    import txalarm_pkg::*;
#(
    parameter int QMAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic pulse
);
    localparam int QW = $clog2(QMAX + 1);
    localparam logic [QW-1:0] FULL = QW'(QMAX);

    febe_state_e   state_q, state_d;
    logic [QW-1:0] pend_q, pend_d;
    logic          take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FB_IDLE;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            FB_IDLE: begin
                if (pend_q != '0) begin
                    state_d = FB_PULSE;
                    take    = 1'b1;
                end
            end
            FB_PULSE: state_d = FB_GAP;
            FB_GAP:   state_d = FB_IDLE;
            default:  state_d = FB_IDLE;
        endcase
    end

    always_comb begin
        pend_d = pend_q;
        if (strobe && !take && pend_q != FULL) pend_d = pend_q + 1'b1;
        else if (!strobe && take)              pend_d = pend_q - 1'b1;
    end

    assign pulse = (state_q == FB_PULSE);

endmodule

// File: rtl/txalarm_ctrl.sv
module txalarm_ctrl #(
    parameter int TMO_MS    = 100,
    parameter int FEBE_QMAX = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_los,
    input  logic tx_clk_lost,
    input  logic rx_frame_lost,
    input  logic rx_mf_lost,
    input  logic crc_err,
    input  logic ms_tick,
    input  logic en_ais_los,
    input  logic en_ais_tloc,
    input  logic en_yel_frm,
    input  logic en_yel_tmo,
    input  logic en_myel,
    input  logic en_febe,
    input  logic man_ais,
    input  logic man_yel,
    input  logic man_myel,
    input  logic man_febe,
    output logic tx_ais,
    output logic ais_clk_alt,
    output logic tx_yel,
    output logic tx_myel,
    output logic tx_febe
);
    logic tmo_expired;
    logic febe_pulse;
    logic tloc_cause;

    txalarm_reframe_timer #(.TMO_MS(TMO_MS)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_lost (rx_frame_lost),
        .ms_tick    (ms_tick),
        .expired    (tmo_expired)
    );

    txalarm_febe_queue #(.QMAX(FEBE_QMAX)) u_febe (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (crc_err & en_febe),
        .pulse  (febe_pulse)
    );

    assign tloc_cause = en_ais_tloc & tx_clk_lost;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_ais      <= 1'b0;
            ais_clk_alt <= 1'b0;
            tx_yel      <= 1'b0;
            tx_myel     <= 1'b0;
            tx_febe     <= 1'b0;
        end else begin
            tx_ais      <= man_ais | tloc_cause | (en_ais_los & rx_los);
            ais_clk_alt <= tloc_cause;
            tx_yel      <= man_yel | (en_yel_frm & rx_frame_lost)
                                   | (en_yel_tmo & tmo_expired);
            tx_myel     <= man_myel | (en_myel & rx_mf_lost);
            tx_febe     <= man_febe | febe_pulse;
        end
    end

endmodule

// File: rtl/txalarm_ctrl_chk.sv
module txalarm_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_los,
    input logic tx_clk_lost,
    input logic rx_frame_lost,
    input logic rx_mf_lost,
    input logic en_ais_los,
    input logic en_ais_tloc,
    input logic en_yel_frm,
    input logic en_myel,
    input logic man_ais,
    input logic man_yel,
    input logic man_myel,
    input logic man_febe,
    input logic tx_ais,
    input logic ais_clk_alt,
    input logic tx_yel,
    input logic tx_myel,
    input logic tx_febe
);
    a_r2_los_gives_ais: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ais_los && rx_los) |=> tx_ais);

    a_r3_alt_needs_ais: assert property (@(posedge clk) disable iff (!rst_n)
        ais_clk_alt |-> tx_ais);

    a_r3_tloc_gives_alt: assert property (@(posedge clk) disable iff (!rst_n)
        (en_ais_tloc && tx_clk_lost) |=> (tx_ais && ais_clk_alt));

    a_r4_frame_loss_yel: assert property (@(posedge clk) disable iff (!rst_n)
        (en_yel_frm && rx_frame_lost) |=> tx_yel);

    a_r7_mf_loss_myel: assert property (@(posedge clk) disable iff (!rst_n)
        (en_myel && rx_mf_lost) |=> tx_myel);

    a_r8_febe_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_febe && !man_febe && !$past(man_febe)) |=> !tx_febe);

    a_r9_manual_force: assert property (@(posedge clk) disable iff (!rst_n)
        (man_ais && man_yel && man_myel && man_febe)
            |=> (tx_ais && tx_yel && tx_myel && tx_febe));

    a_r10_ais_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_ais && !(en_ais_los && rx_los) && !(en_ais_tloc && tx_clk_lost))
            |=> !tx_ais);

    a_r10_myel_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!man_myel && !(en_myel && rx_mf_lost)) |=> !tx_myel);

endmodule

bind txalarm_ctrl txalarm_ctrl_chk u_chk (.*);

// File: tb/sim_txalarm_ctrl.sv
module sim_txalarm_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_los = 0, tx_clk_lost = 0, rx_frame_lost = 0, rx_mf_lost = 0;
    logic crc_err = 0, ms_tick = 0;
    logic en_ais_los = 0, en_ais_tloc = 0, en_yel_frm = 0, en_yel_tmo = 0;
    logic en_myel = 0, en_febe = 0;
    logic man_ais = 0, man_yel = 0, man_myel = 0, man_febe = 0;
    logic tx_ais, ais_clk_alt, tx_yel, tx_myel, tx_febe;

    localparam int TMO = 100;

    always #5 clk = ~clk;

    txalarm_ctrl #(.TMO_MS(TMO), .FEBE_QMAX(7)) u0 (.*);

    // scoreboard: kind 0 = output vector {ais,alt,yel,myel,febe}, kind 1 = FEBE edge count
    string tag_q[$];
    int    kind_q[$];
    int    exp_q[$];
    int    errors = 0;
    int    checks = 0;
    int    febe_edges = 0;
    int    cycles = 0;
    logic  febe_prev = 1'b0;
    logic  done = 1'b0;

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push_vec(input string tag, input logic [4:0] v);
        tag_q.push_back(tag); kind_q.push_back(0); exp_q.push_back(int'(v));
    endtask

    task automatic push_cnt(input string tag, input int n);
        tag_q.push_back(tag); kind_q.push_back(1); exp_q.push_back(n);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1; step(1);
            ms_tick = 1'b0; step(1);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        cycles++;
        if (tx_febe && !febe_prev) febe_edges++;
        febe_prev = tx_febe;
        while (tag_q.size() > 0) begin
            string t;
            int k, e, a;
            t = tag_q.pop_front(); k = kind_q.pop_front(); e = exp_q.pop_front();
            a = (k == 0) ? int'({tx_ais, ais_clk_alt, tx_yel, tx_myel, tx_febe}) : febe_edges;
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual=%0h expected=%0h", t, a, e);
            end
        end
        if (cycles > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        step(3);
        push_vec("R1 in reset", 5'b00000);
        rst_n = 1'b1;
        step(1);
        push_vec("R1 after reset", 5'b00000);

        // R2
        rx_los = 1; step(1);
        push_vec("R2 los ignored when disabled", 5'b00000);
        en_ais_los = 1; step(1);
        push_vec("R2 ais from los", 5'b10000);
        rx_los = 0; step(1);
        push_vec("R10 ais drops after los clears", 5'b00000);
        en_ais_los = 0;

        // R3
        tx_clk_lost = 1; step(1);
        push_vec("R3 tloc ignored when disabled", 5'b00000);
        en_ais_tloc = 1; step(1);
        push_vec("R3 ais with alt clock", 5'b11000);
        tx_clk_lost = 0; step(1);
        push_vec("R10 ais and alt drop", 5'b00000);
        en_ais_tloc = 0;

        // R4
        en_yel_frm = 1; rx_frame_lost = 1; step(1);
        push_vec("R4 yel on frame loss", 5'b00100);
        rx_frame_lost = 0; step(1);
        push_vec("R10 yel drops", 5'b00000);
        en_yel_frm = 0;

        // R7
        en_myel = 1; rx_mf_lost = 1; step(1);
        push_vec("R7 myel on mf loss", 5'b00010);
        en_myel = 0; step(1);
        push_vec("R10 myel drops on enable low", 5'b00000);
        rx_mf_lost = 0;

        // R5 / R6 reframe timer
        en_yel_tmo = 1; rx_frame_lost = 1; step(2);
        ticks(TMO - 1);
        push_vec("R5 no yel one tick early", 5'b00000);
        ms_tick = 1; step(1); ms_tick = 0; step(1);
        push_vec("R5 yel at timeout", 5'b00100);
        ticks(5);
        push_vec("R5 yel held", 5'b00100);
        rx_frame_lost = 0; step(2);
        push_vec("R6 yel drops after realign", 5'b00000);
        rx_frame_lost = 1; step(2);
        ticks(TMO - 1);
        push_vec("R6 timer restarted from zero", 5'b00000);
        ticks(1); step(1);
        push_vec("R6 second timeout", 5'b00100);
        rx_frame_lost = 0; en_yel_tmo = 0; step(3);

        // R8 FEBE queue
        base = febe_edges;
        crc_err = 1; step(3); crc_err = 0; step(40);
        push_cnt("R8 strobes ignored when disabled", base);
        step(1);
        base = febe_edges;
        en_febe = 1;
        crc_err = 1; step(4); crc_err = 0; step(40);
        push_cnt("R8 four back-to-back strobes", base + 4);
        step(1);
        base = febe_edges;
        for (int i = 0; i < 3; i++) begin
            crc_err = 1; step(1); crc_err = 0; step(5);
        end
        step(20);
        push_cnt("R8 three spaced strobes", base + 3);
        en_febe = 0; step(2);

        // R9 manual
        man_ais = 1; man_yel = 1; man_myel = 1; man_febe = 1; step(1);
        push_vec("R9 all manual on", 5'b10111);
        man_ais = 0; man_yel = 0; man_myel = 0; man_febe = 0; step(1);
        push_vec("R9 manual released", 5'b00000);
        man_ais = 1; en_ais_tloc = 1; step(1);
        push_vec("R3 manual ais without alt", 5'b10000);
        man_ais = 0; en_ais_tloc = 0;
        step(3);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule